// File: doc/BRIEF.md
# Synchronization Status Message Scheduler and Receive Timeout Monitor

This block sits on one synchronous-Ethernet port and decides when a synchronization status message must be sent and what quality level it carries. It raises a request for a periodic information message once per second and an immediate event message whenever the selected clock reference changes. Each request carries a 4-bit quality level. The request is held until the transmit path acknowledges it. The port that feeds the selected reference always advertises the do-not-use level back toward its upstream neighbour, so the two devices cannot lock to each other.

On the receive side the block counts seconds since the last information message arrived on the port. After a configurable number of silent seconds it flags the port's clock as lost. Time is measured in pulses of an external tick, with a parameter giving the ticks per second. This lets a simulation run short seconds. When the port is disabled, both timers are held cleared and the block issues nothing.

Top module: `esmc_sched`

## Requirements
- R1: After reset, `tx_req` and `ref_lost` are 0.
- R2: While `port_en` is 1, a request with `tx_event`=0 (information message) is raised after every TICKS_PER_SEC tick pulses. It is visible in the cycle after the tick that completes the second.
- R3: A `ref_chg` pulse while enabled raises a request with `tx_event`=1 in the next cycle. It also restarts the periodic timer, so the next information request follows TICKS_PER_SEC ticks after that pulse.
- R4: When `ref_chg` and the completing tick of a second fall in the same cycle, exactly one request is made, and `tx_event` is 1. No information request follows until a further full second has passed.
- R5: A raised request stays high until a cycle with `tx_ack`=1. Periodic deadlines that occur while it is outstanding are absorbed. An outstanding event request stays of event type.
- R6: `tx_ql` equals 4'hF (do-not-use) while `trace_port` is 1; otherwise it equals `ref_ql`.
- R7: `ref_lost` becomes 1 in the cycle after the TIMEOUT_SEC*TICKS_PER_SEC-th tick without an `rx_info` pulse.
- R8: An `rx_info` pulse clears the silence count and makes `ref_lost` 0 in the next cycle. This holds even when it coincides with the tick that would have expired the timeout.
- R9: While `port_en` is 0, `tx_req` and `ref_lost` are 0 from the next cycle on. Both timers restart from zero when the port is enabled again.
- R10: In cycles without a tick, neither timer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enabled for message exchange |
| tick | input | 1 | Time-base pulse, TICKS_PER_SEC per second |
| ref_ql | input | 4 | Quality level of the selected reference |
| ref_chg | input | 1 | Pulse: selected reference changed |
| trace_port | input | 1 | This port feeds the selected reference |
| rx_info | input | 1 | Pulse: information message received |
| tx_ack | input | 1 | Transmit path accepted the request |
| tx_req | output | 1 | Message send request |
| tx_event | output | 1 | 1 = event message, 0 = information message |
| tx_ql | output | 4 | Quality level to place in the message |
| ref_lost | output | 1 | Port clock declared lost |

## Verification
Two pairs of triggers can fall in one cycle. The first pair is a reference change and the tick that ends a second. The bench places `ref_chg` on exactly that tick and checks for a single event request, followed by a full second of silence. The second pair is a received message and the tick that would expire the timeout. The bench pulses `rx_info` on the last tick before expiry and checks that `ref_lost` stays 0 and that the count restarts. Both are judged against cycle counts computed from TICKS_PER_SEC and TIMEOUT_SEC.

// File: rtl/esmc_pkg.sv
// Shared types for the status-message scheduler.
package esmc_pkg;
    typedef enum logic {
        MSG_INFO  = 1'b0,
        MSG_EVENT = 1'b1
    } msg_kind_e;

    localparam int QL_W = 4;
    localparam logic [QL_W-1:0] QL_DNU = 4'hF;
endpackage

// File: rtl/esmc_tick_timer.sv
// Tick counter with a terminal count.
// Counts tick pulses. `hit` is high in the cycle of the LIMIT-th tick.
// With WRAP=1 the count returns to zero after a hit; with WRAP=0 it saturates.
// Assumes LIMIT >= 2. A clear has priority over a tick and suppresses hit.
module esmc_tick_timer #(
    parameter int LIMIT = 4,
    parameter bit WRAP  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == LAST);
    assign hit     = tick && at_last && !clr;

    // Count ticks; on terminal count either wrap or hold.
    generate
        if (WRAP) begin : g_wrap
            always_ff @(posedge clk) begin
                if (!rst_n || clr)  cnt <= '0;
                else if (tick)      cnt <= at_last ? '0 : cnt + 1'b1;
            end
        end else begin : g_sat
            always_ff @(posedge clk) begin
                if (!rst_n || clr)          cnt <= '0;
                else if (tick && !at_last)  cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/esmc_tx_req.sv
// Transmit request holder.
// Holds one outstanding request and its kind until acknowledged.
// An event trigger always (re)arms as event; a periodic deadline arms an info
// request only when nothing is outstanding or the current one is being acked.
module esmc_tx_req
    import esmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      port_en,
    input  logic      ev_due,
    input  logic      info_due,
    input  logic      ack,
    output logic      req,
    output msg_kind_e kind
);
    // Arm, upgrade, or clear the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_en) begin
            req  <= 1'b0;
            kind <= MSG_INFO;
        end else if (ev_due) begin
            req  <= 1'b1;
            kind <= MSG_EVENT;
        end else if (info_due && (!req || ack)) begin
            req  <= 1'b1;
            kind <= MSG_INFO;
        end else if (ack) begin
            req  <= 1'b0;
        end
    end
endmodule

// File: rtl/esmc_sched.sv
// Status-message scheduler and receive timeout monitor for one port.
// Issues periodic info and immediate event send requests; forces the
// do-not-use level on the port feeding the reference; declares the port
// clock lost after TIMEOUT_SEC silent seconds. Assumes single-cycle pulses on
// ref_chg and rx_info, and tick pulses at TICKS_PER_SEC per second.
module esmc_sched
    import esmc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int TIMEOUT_SEC   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_en,
    input  logic            tick,
    input  logic [QL_W-1:0] ref_ql,
    input  logic            ref_chg,
    input  logic            trace_port,
    input  logic            rx_info,
    input  logic            tx_ack,
    output logic            tx_req,
    output logic            tx_event,
    output logic [QL_W-1:0] tx_ql,
    output logic            ref_lost
);
    localparam int RX_LIMIT = TIMEOUT_SEC * TICKS_PER_SEC;

    logic      ev_due;
    logic      info_due;
    logic      rx_hit;
    msg_kind_e kind;

    assign ev_due = port_en && ref_chg;

    // Periodic information timer, restarted by an event or disable.
    esmc_tick_timer #(.LIMIT(TICKS_PER_SEC), .WRAP(1'b1)) u_tx_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!port_en || ref_chg),
        .tick (tick),
        .hit  (info_due)
    );

    // Receive silence timer, restarted by each received message.
    esmc_tick_timer #(.LIMIT(RX_LIMIT), .WRAP(1'b0)) u_rx_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!port_en || rx_info),
        .tick (tick),
        .hit  (rx_hit)
    );

    esmc_tx_req u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_en (port_en),
        .ev_due  (ev_due),
        .info_due(info_due),
        .ack     (tx_ack),
        .req     (tx_req),
        .kind    (kind)
    );

    assign tx_event = (kind == MSG_EVENT);

    // Loop prevention: the reference-feeding port advertises do-not-use.
    assign tx_ql = trace_port ? QL_DNU : ref_ql;

    // Lost flag: set on timeout, cleared by reception or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_en || rx_info) ref_lost <= 1'b0;
        else if (rx_hit)                   ref_lost <= 1'b1;
    end
endmodule

// File: rtl/esmc_sched_chk.sv
// Property checker for esmc_sched, attached by bind.
module esmc_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic tick,
    input logic ref_chg,
    input logic rx_info,
    input logic tx_ack,
    input logic tx_req,
    input logic tx_event,
    input logic ref_lost
);
    // R9
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!tx_req && !ref_lost));
    // R3
    a_r3_event: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && ref_chg) |=> (tx_req && tx_event));
    // R5
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && tx_req && !tx_ack) |=> tx_req);
    // R5
    a_r5_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && tx_req && tx_event && !tx_ack) |=> tx_event);
    // R8
    a_r8_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && rx_info) |=> !ref_lost);
    // R10
    a_r10_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && !tick && !ref_chg && !tx_ack && !rx_info)
        |=> ($stable(tx_req) && $stable(ref_lost)));
    // R7
    a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_lost) |-> $past(tick));
endmodule

bind esmc_sched esmc_sched_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_en (port_en),
    .tick    (tick),
    .ref_chg (ref_chg),
    .rx_info (rx_info),
    .tx_ack  (tx_ack),
    .tx_req  (tx_req),
    .tx_event(tx_event),
    .ref_lost(ref_lost)
);

// File: tb/test_esmc_sched.sv
module test_esmc_sched;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 4;
    localparam int TS  = 5;
    localparam int LIM = P * TS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       tick = 1'b1;
    logic [3:0] ref_ql = 4'h2;
    logic       ref_chg = 1'b0;
    logic       trace_port = 1'b0;
    logic       rx_info = 1'b0;
    logic       tx_ack = 1'b0;
    logic       tx_req, tx_event, ref_lost;
    logic [3:0] tx_ql;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  auto_ack = 1'b1;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    esmc_sched #(.TICKS_PER_SEC(P), .TIMEOUT_SEC(TS)) i_esmc_sched (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .tick(tick),
        .ref_ql(ref_ql), .ref_chg(ref_chg), .trace_port(trace_port),
        .rx_info(rx_info), .tx_ack(tx_ack), .tx_req(tx_req),
        .tx_event(tx_event), .tx_ql(tx_ql), .ref_lost(ref_lost)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    // One clock edge; sample 1 time unit after it, then drive.
    task automatic step();
        @(posedge clk);
        #1;
        if (auto_ack) tx_ack = tx_req;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) step();
        chk("R1 tx_req", tx_req, 0);
        chk("R1 ref_lost", ref_lost, 0);
        rst_n = 1'b1;
        step();
        chk("R9 disabled no req", tx_req, 0);

        // R2 periodic sweep from enable
        port_en = 1'b1;
        for (int e = 1; e <= 4*P; e++) begin
            step();
            chk("R2 periodic req", tx_req, (e % P == 0));
            if (e % P == 0) chk("R2 info kind", tx_event, 0);
        end
        step();
        chk("R2 acked clear", tx_req, 0);

        // R3 event then restarted period
        ref_chg = 1'b1; ref_ql = 4'h4;
        step();
        ref_chg = 1'b0;
        chk("R3 event req", tx_req, 1);
        chk("R3 event kind", tx_event, 1);
        chk("R3 event ql", tx_ql, 4);
        for (int e = 1; e <= 2*P; e++) begin
            step();
            chk("R3 restarted period", tx_req, (e % P == 0));
            if (e % P == 0) chk("R3 info after event", tx_event, 0);
        end

        // R4 collision: event on the completing tick
        for (int e = 1; e <= P-1; e++) step();
        chk("R4 pre collision idle", tx_req, 0);
        ref_chg = 1'b1;
        step();
        ref_chg = 1'b0;
        chk("R4 single req", tx_req, 1);
        chk("R4 event kind", tx_event, 1);
        for (int e = 1; e <= P-1; e++) begin
            step();
            chk("R4 no extra info", tx_req, 0);
        end
        step();
        chk("R4 info one second later", tx_req, 1);
        chk("R4 info kind", tx_event, 0);
        step();

        // R5 hold without ack, deadlines absorbed
        auto_ack = 1'b0; tx_ack = 1'b0;
        ref_chg = 1'b1;
        step();
        ref_chg = 1'b0;
        for (int e = 1; e <= 3*P; e++) begin
            step();
            chk("R5 held req", tx_req, 1);
            chk("R5 held event kind", tx_event, 1);
        end
        tx_ack = 1'b1;
        step();
        tx_ack = 1'b0;
        chk("R5 ack clears", tx_req, 0);
        auto_ack = 1'b1;

        // R6 quality sweep over both trace states
        for (int t = 0; t < 2; t++) begin
            for (int q = 0; q < 16; q++) begin
                trace_port = t[0]; ref_ql = q[3:0];
                #1;
                chk("R6 tx_ql", tx_ql, t ? 15 : q);
            end
        end
        trace_port = 1'b0; ref_ql = 4'h2;

        // R9 disable clears and suppresses
        port_en = 1'b0;
        step();
        chk("R9 req off", tx_req, 0);
        chk("R9 lost off", ref_lost, 0);
        for (int e = 1; e <= 3*P; e++) begin
            step();
            chk("R9 no req while disabled", tx_req, 0);
        end

        // R7 timeout sweep from enable
        port_en = 1'b1;
        for (int e = 1; e <= LIM+2; e++) begin
            step();
            chk("R7 lost timing", ref_lost, (e >= LIM));
        end
        // R8 reception clears
        rx_info = 1'b1;
        step();
        rx_info = 1'b0;
        chk("R8 rx clears lost", ref_lost, 0);
        for (int e = 1; e <= LIM-1; e++) step();
        chk("R8 not yet lost", ref_lost, 0);
        // R8 rx on the expiring tick wins
        rx_info = 1'b1;
        step();
        rx_info = 1'b0;
        chk("R8 rx beats timeout", ref_lost, 0);
        for (int e = 1; e <= LIM; e++) begin
            step();
            chk("R8 restarted count", ref_lost, (e >= LIM));
        end

        // R10 no tick, no progress
        rx_info = 1'b1;
        step();
        rx_info = 1'b0;
        tick = 1'b0;
        for (int e = 1; e <= 3*LIM; e++) begin
            step();
            chk("R10 lost frozen", ref_lost, 0);
            chk("R10 no periodic req", tx_req, 0);
        end
        tick = 1'b1;
        for (int e = 1; e <= LIM; e++) step();
        chk("R10 resumes count", ref_lost, 1);

        // R9 disable drops lost flag
        port_en = 1'b0;
        step();
        chk("R9 lost cleared on disable", ref_lost, 0);

        done = 1'b1;
        summary();
    end
endmodule